// File: doc/BRIEF.md
# Compare-Capture Timer/Counter

This block is a timer/counter with four compare/capture channels. Software drives it through a 32-bit register port. Some addresses are task triggers, some are per-channel event flags, and the rest are configuration registers. In timer mode the counter advances once per prescaled tick of the system clock. In counter mode it advances once per software COUNT task. The counter wraps at a width that is chosen at run time.

Each channel holds a compare value and a sticky event flag. The flag is set when the counter lands on the channel value. Per-channel shortcut bits can turn that match into an automatic counter clear, an automatic stop, or both. A capture task copies the live counter into a channel. One level interrupt output combines the event flags with per-channel enable bits.

Top module: `cmp_timer`

## Requirements
- R1: The width code at offset 0x94 (bits 1:0) selects the counter width: code 0 gives 16 bits, code 1 gives 8 bits, code 2 gives 24 bits and code 3 gives 32 bits. The counter wraps to 0 after the all-ones value of that width.
- R2: A write to the channel i value at 0xC0+4i keeps only the bits below the current width.
- R3: The mode register at 0x90 uses bit 0: 0 selects timer, 1 selects counter. START at 0x00 sets the block running only in timer mode. While running, the counter advances once every 2^P system clocks, where P is the 4-bit prescaler at 0x98.
- R4: The COUNT task at 0x08 adds one to the counter only in counter mode. It has no effect in timer mode.
- R5: On the clock after an increment leaves the counter equal to channel i's value, the event flag at 0x40+4i reads 1. Writing 0 to that address clears the flag.
- R6: When shortcut bit i at 0x80 is set, a match on channel i clears the counter to 0. A capture in the match cycle still sees the value before the clear.
- R7: When shortcut bit 8+i is set, a match on channel i stops timer counting with no further increment. If both bits are set, the counter clears to 0 and the block stops.
- R8: irq_o is high when any channel has both its event flag set and its enable bit 16+i set.
- R9: Writing to 0x84 ORs the written enable bits into the enable register. Writing to 0x88 clears the written bits. Reading either address returns the enable register.
- R10: STOP at 0x04 and HALT at 0x10 both end timer counting. CLEAR at 0x0C sets the counter to 0.
- R11: The CAPTURE task at 0x20+4i copies the counter into channel i's value.
- R12: A task fires only when the written data equals 1. Unmapped offsets read as 0.
- R13: Reset returns every register, flag and the counter to 0, including mode, width and prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A compare match with a clear shortcut and a software capture can land on the same clock edge. The bench provokes this by issuing a CAPTURE write in the cycle right after the COUNT write that reaches the compare value. It judges the result by reading back the captured value, which must be the pre-clear count. A second capture must then read 0. Shortcut stop and shortcut clear firing on one match are checked the same way, by capturing after the block has settled.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SC_STOP_LSB = 8;
  localparam int IEN_LSB = 16;

  localparam logic [ADDR_W-1:0] OFS_START  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STOP   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_HALT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CAP0   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EVT0   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_SHORTS = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_IENSET = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_IENCLR = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_WIDTH  = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_PRESC  = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_CC0    = 8'hC0;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNTER = 1'b1} mode_e;

  function automatic logic [ADDR_W-1:0] ch_ofs(input logic [ADDR_W-1:0] base, input int ch);
    return base + ADDR_W'(4 * ch);
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    return DATA_W'(32'h0000_FFFF);
      2'd1:    return DATA_W'(32'h0000_00FF);
      2'd2:    return DATA_W'(32'h00FF_FFFF);
      default: return {DATA_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
  parameter int PRESC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  localparam int DIV_W = (1 << PRESC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] sel_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // low presc_i bits of the divider all ones -> one tick per 2^presc_i clocks
  assign sel_mask = ~({DIV_W{1'b1}} << presc_i);
  assign tick_o   = &(div_q | ~sel_mask);
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic [W-1:0] mask_i,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         count_i,
  input  logic         clear_i,
  input  logic         sc_clr_i,
  input  logic         sc_stop_i,
  output logic [W-1:0] cnt_o,
  output logic         run_o,
  output logic         upd_o
);
  logic [W-1:0] cnt_q;
  logic         run_q, upd_q;
  logic         inc, zero;

  assign inc  = ((mode_i == MODE_TIMER) && run_q && tick_i) ||
                ((mode_i == MODE_COUNTER) && count_i);
  assign zero = clear_i || sc_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      // clear beats increment; a stop match also swallows the increment
      if (zero)                     cnt_q <= '0;
      else if (inc && !sc_stop_i)   cnt_q <= (cnt_q + 1'b1) & mask_i;
      upd_q <= inc && !sc_stop_i && !zero;
      if (stop_i || sc_stop_i)                     run_q <= 1'b0;
      else if (start_i && mode_i == MODE_TIMER)    run_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cc_we_i,
  input  logic [W-1:0] cc_wdata_i,
  input  logic         cap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         upd_i,
  input  logic         evt_clr_i,
  output logic [W-1:0] cc_o,
  output logic         evt_o,
  output logic         hit_o
);
  logic [W-1:0] cc_q;
  logic         evt_q;

  assign hit_o = upd_i && (cnt_i == cc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q  <= '0;
      evt_q <= 1'b0;
    end else begin
      if (cap_i)        cc_q <= cnt_i;
      else if (cc_we_i) cc_q <= cc_wdata_i;
      if (hit_o)          evt_q <= 1'b1;
      else if (evt_clr_i) evt_q <= 1'b0;
    end
  end

  assign cc_o  = cc_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CH_N    = 4,
  parameter int PRESC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              trig;
  logic              start_t, stop_t, count_t, clear_t;
  mode_e             mode_q;
  logic [1:0]        width_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CH_N-1:0]   sc_clr_q, sc_stop_q, ien_q;
  logic [DATA_W-1:0] mask;
  logic              tick;
  logic [DATA_W-1:0] cnt;
  logic              running, upd;
  logic [CH_N-1:0]   hit, evt;
  logic [DATA_W-1:0] cc [CH_N];

  assign trig    = wr_en_i && (wdata_i == DATA_W'(1));
  assign start_t = trig && addr_i == OFS_START;
  assign stop_t  = trig && (addr_i == OFS_STOP || addr_i == OFS_HALT);
  assign count_t = trig && addr_i == OFS_COUNT;
  assign clear_t = trig && addr_i == OFS_CLEAR;
  assign mask    = width_mask(width_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TIMER;
      width_q   <= '0;
      presc_q   <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      ien_q     <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_MODE:   mode_q  <= mode_e'(wdata_i[0]);
        OFS_WIDTH:  width_q <= wdata_i[1:0];
        OFS_PRESC:  presc_q <= wdata_i[PRESC_W-1:0];
        OFS_SHORTS: begin
          sc_clr_q  <= wdata_i[CH_N-1:0];
          sc_stop_q <= wdata_i[SC_STOP_LSB +: CH_N];
        end
        OFS_IENSET: ien_q <= ien_q | wdata_i[IEN_LSB +: CH_N];
        OFS_IENCLR: ien_q <= ien_q & ~wdata_i[IEN_LSB +: CH_N];
        default: ;
      endcase
    end
  end

  cmp_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .presc_i(presc_q),
    .tick_o (tick)
  );

  cmp_timer_core #(.W(DATA_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_q),
    .mask_i   (mask),
    .tick_i   (tick),
    .start_i  (start_t),
    .stop_i   (stop_t),
    .count_i  (count_t),
    .clear_i  (clear_t),
    .sc_clr_i (|(hit & sc_clr_q)),
    .sc_stop_i(|(hit & sc_stop_q)),
    .cnt_o    (cnt),
    .run_o    (running),
    .upd_o    (upd)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    cmp_timer_chan #(.W(DATA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cc_we_i   (wr_en_i && addr_i == ch_ofs(OFS_CC0, i)),
      .cc_wdata_i(wdata_i & mask),
      .cap_i     (trig && addr_i == ch_ofs(OFS_CAP0, i)),
      .cnt_i     (cnt),
      .upd_i     (upd),
      .evt_clr_i (wr_en_i && addr_i == ch_ofs(OFS_EVT0, i) && wdata_i == '0),
      .cc_o      (cc[i]),
      .evt_o     (evt[i]),
      .hit_o     (hit[i])
    );
  end

  assign irq_o = |(evt & ien_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE:   rdata_o = DATA_W'(mode_q);
      OFS_WIDTH:  rdata_o = DATA_W'(width_q);
      OFS_PRESC:  rdata_o = DATA_W'(presc_q);
      OFS_SHORTS: begin
        rdata_o[CH_N-1:0]            = sc_clr_q;
        rdata_o[SC_STOP_LSB +: CH_N] = sc_stop_q;
      end
      OFS_IENSET, OFS_IENCLR: rdata_o[IEN_LSB +: CH_N] = ien_q;
      default: ;
    endcase
    for (int i = 0; i < CH_N; i++) begin
      if (addr_i == ch_ofs(OFS_EVT0, i)) rdata_o = DATA_W'(evt[i]);
      if (addr_i == ch_ofs(OFS_CC0, i))  rdata_o = cc[i];
    end
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int CH_N = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [DATA_W-1:0] cnt,
  input logic              running,
  input logic              upd,
  input logic [CH_N-1:0]   evt,
  input logic [CH_N-1:0]   sc_stop_q,
  input mode_e             mode_q,
  input logic [DATA_W-1:0] cc0
);
  // R8: interrupt only with a pending event
  a_r8_irq_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt != '0));

  // R3: START in counter mode leaves the block idle
  a_r3_start_timer_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_START && wdata_i == DATA_W'(1) &&
     mode_q == MODE_COUNTER && !running) |=> !running);

  // R10: CLEAR task zeroes the counter
  a_r10_clear_task: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CLEAR && wdata_i == DATA_W'(1)) |=> (cnt == '0));

  // R7: stop shortcut on channel 0 halts counting
  a_r7_stop_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && cnt == cc0 && sc_stop_q[0]) |=> !running);

  // R5: an event flag only rises after a counter update
  a_r5_event_from_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt[0]) |-> $past(upd));

  // R4: idle counter with no access holds its value
  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running && !wr_en_i && !upd) |=> $stable(cnt));
endmodule

bind cmp_timer cmp_timer_chk #(.CH_N(CH_N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .cnt      (cnt),
  .running  (running),
  .upd      (upd),
  .evt      (evt),
  .sc_stop_q(sc_stop_q),
  .mode_q   (mode_q),
  .cc0      (cc[0])
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] A_START = 8'h00, A_STOP = 8'h04, A_COUNT = 8'h08,
    A_CLEAR = 8'h0C, A_HALT = 8'h10, A_CAP = 8'h20, A_EVT = 8'h40,
    A_SHORTS = 8'h80, A_IENSET = 8'h84, A_IENCLR = 8'h88, A_MODE = 8'h90,
    A_WIDTH = 8'h94, A_PRESC = 8'h98, A_CC = 8'hC0;

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_MODE,   32'h1,     8'd4},
    '{1'b0, A_WIDTH,  32'h1,     8'd1},
    '{1'b0, A_CC,     32'h123,   8'd2},
    '{1'b1, A_CC,     32'h23,    8'd2},   // R2 masked to 8 bits
    '{1'b0, A_CC+4,   32'h2,     8'd6},
    '{1'b0, A_SHORTS, 32'h2,     8'd6},
    '{1'b0, A_COUNT,  32'h1,     8'd4},
    '{1'b0, A_COUNT,  32'h1,     8'd4},
    '{1'b1, A_EVT+4,  32'h1,     8'd5},   // R5 match on channel 1
    '{1'b0, A_CAP+8,  32'h1,     8'd11},
    '{1'b1, A_CC+8,   32'h0,     8'd6},   // R6 cleared by shortcut
    '{1'b0, A_COUNT,  32'h1,     8'd4},
    '{1'b0, A_COUNT,  32'h0,     8'd12},
    '{1'b0, A_CAP+12, 32'h1,     8'd11},
    '{1'b1, A_CC+12,  32'h1,     8'd12},  // R12 zero-data task ignored
    '{1'b0, A_EVT+4,  32'h0,     8'd5},
    '{1'b1, A_EVT+4,  32'h0,     8'd5},
    '{1'b0, A_IENSET, 32'h20000, 8'd9},
    '{1'b1, A_IENCLR, 32'h20000, 8'd9},   // R9
    '{1'b0, A_IENCLR, 32'h20000, 8'd9},
    '{1'b1, A_IENSET, 32'h0,     8'd9},
    '{1'b1, 8'hFC,    32'h0,     8'd12}   // R12 unmapped
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string r);
    idle(1);
    addr = a; #1;
    chk(r, rdata, exp);
    addr = '0;
  endtask

  task automatic rd_val(input logic [7:0] a, output logic [31:0] v);
    idle(1);
    addr = a; #1;
    v = rdata;
    addr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R13 reset state
    rd_chk(A_MODE, 0, "R13");
    rd_chk(A_WIDTH, 0, "R13");
    rd_chk(A_PRESC, 0, "R13");
    rd_chk(A_SHORTS, 0, "R13");
    rd_chk(A_IENSET, 0, "R13");
    rd_chk(A_CC, 0, "R13");
    rd_chk(A_EVT, 0, "R13");
    chk("R13 irq", {31'b0, irq}, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].rd) rd_chk(VEC[k].a, VEC[k].d, $sformatf("R%0d vec %0d", VEC[k].req, k));
      else           wr(VEC[k].a, VEC[k].d);
    end

    // R8 interrupt from event 1 and enable bit 17 (counter 1 -> 2 matches CC1)
    wr(A_IENSET, 32'h20000);
    wr(A_COUNT, 1);
    idle(1);
    chk("R8 irq set", {31'b0, irq}, 1);
    wr(A_IENCLR, 32'h20000);
    idle(1);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(A_IENSET, 32'h20000);
    wr(A_EVT + 4, 0);
    idle(1);
    chk("R8 irq after event clear", {31'b0, irq}, 0);
    wr(A_IENCLR, 32'h20000);

    // R1 8-bit wrap
    wr(A_CLEAR, 1);
    wr(A_SHORTS, 0);
    wr(A_CC, 0);
    wr(A_EVT, 0);
    for (int k = 0; k < 256; k++) wr(A_COUNT, 1);
    rd_chk(A_EVT, 1, "R1 wrap event");
    wr(A_CAP + 4, 1);
    rd_chk(A_CC + 4, 0, "R1 wrap value");
    // R2 masking per width code
    wr(A_WIDTH, 0); wr(A_CC, 32'hABCDEF12); rd_chk(A_CC, 32'h0000EF12, "R2 w16");
    wr(A_WIDTH, 2); wr(A_CC, 32'hABCDEF12); rd_chk(A_CC, 32'h00CDEF12, "R2 w24");
    wr(A_WIDTH, 3); wr(A_CC, 32'hABCDEF12); rd_chk(A_CC, 32'hABCDEF12, "R2 w32");

    // R6 R11 capture in the same cycle as a shortcut clear
    wr(A_WIDTH, 1);
    wr(A_CLEAR, 1);
    wr(A_CC, 3);
    wr(A_SHORTS, 1);
    wr(A_COUNT, 1); wr(A_COUNT, 1); wr(A_COUNT, 1);
    wr(A_CAP + 4, 1);
    wr(A_CAP + 8, 1);
    rd_chk(A_CC + 4, 3, "R11 capture at match edge");
    rd_chk(A_CC + 8, 0, "R6 cleared after match");

    // R3 START ignored in counter mode; R4 COUNT ignored in timer mode
    wr(A_SHORTS, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(20);
    wr(A_CAP, 1);
    rd_chk(A_CC, 0, "R3 start in counter mode");
    wr(A_MODE, 0);
    wr(A_COUNT, 1);
    wr(A_CAP, 1);
    rd_chk(A_CC, 0, "R4 count in timer mode");

    // R7 stop shortcut, prescaler 0
    wr(A_WIDTH, 3);
    wr(A_CC, 5);
    wr(A_SHORTS, 32'h100);
    wr(A_EVT, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(20);
    wr(A_CAP + 4, 1);
    rd_chk(A_CC + 4, 5, "R7 stop at match");
    rd_chk(A_EVT, 1, "R7 event");
    // R7 clear and stop together
    wr(A_SHORTS, 32'h101);
    wr(A_EVT, 0);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(20);
    wr(A_CAP + 4, 1);
    rd_chk(A_CC + 4, 0, "R7 clear then stop");
    rd_chk(A_EVT, 1, "R7 event both");

    // R3 prescaler 3: one tick per 8 clocks
    wr(A_SHORTS, 0);
    wr(A_PRESC, 3);
    wr(A_CLEAR, 1);
    wr(A_START, 1);
    idle(80);
    wr(A_STOP, 1);
    wr(A_CAP + 4, 1);
    rd_val(A_CC + 4, v);
    n_chk++;
    if (v < 9 || v > 11) begin
      n_err++;
      $display("FAIL R3 prescaled count: got %0d expected 9..11", v);
    end
    // R10 STOP holds the count
    idle(20);
    wr(A_CAP + 8, 1);
    rd_chk(A_CC + 8, v, "R10 stop holds");
    // R10 HALT
    wr(A_START, 1);
    idle(30);
    wr(A_HALT, 1);
    wr(A_CAP + 4, 1);
    rd_val(A_CC + 4, v2);
    idle(40);
    wr(A_CAP + 8, 1);
    rd_chk(A_CC + 8, v2, "R10 halt holds");
    n_chk++;
    if (v2 <= v) begin
      n_err++;
      $display("FAIL R3 restart counted: got %0d expected above %0d", v2, v);
    end

    finish_run();
  end
endmodule